// File: doc/BRIEF.md
# Dual JTAG TAP Handover Controller

This block fronts a single set of JTAG pins with two test access ports. The primary TAP is a full IEEE 1149.1 controller with a 16-state machine, a 4-bit instruction register, a one-bit bypass register and a 32-bit identification register. The secondary TAP is a debug port that is hidden after reset. In this block it is a bypass-only stand-in with its own state machine, instruction register and bypass register.

An ownership latch decides which TAP the pins drive. It starts clear, so the primary TAP owns the port. There are two ways to set it. One is to load the handover opcode into the primary instruction register and pass through Update-IR. The other is to hold the debug-event input low across two consecutive rising TCK edges while TRST is high. Once the latch is set, TMS and TDI reach the secondary TAP and TDO comes from it. The primary state machine is then pinned in Test-Logic-Reset. Only a TRST pulse clears the latch, and no TMS sequence does.

Top module: `dual_tap_handover`

## Requirements
- R1: While trst_n is low, sec_active is 0, tdo_oe is 0 and tdo is 0. After trst_n is released, the primary TAP owns the pins and its instruction register selects IDCODE.
- R2: The primary state machine follows the 16-state TAP graph. Five rising TCK edges with TMS high reach Test-Logic-Reset from any state, and entering that state selects IDCODE.
- R3: The primary IR is 4 bits wide and shifts LSB first. Capture-IR loads 4'b0001, so the bits leave as 1,0,0,0. Opcode 4'h2 selects IDCODE and 4'h3 is the handover opcode. Every other opcode, including 4'hF, selects the bypass register.
- R4: With IDCODE selected, Capture-DR loads the 32-bit IDCODE parameter (default 32'h1A5C_E0B3, LSB 1). Shift-DR sends it out LSB first.
- R5: With bypass selected, Capture-DR loads 0. Each TDI bit then appears on TDO one shift cycle later.
- R6: TDO and tdo_oe change only on the falling edge of TCK. tdo_oe is 1 only while the owning TAP is in Shift-IR or Shift-DR, and it is 0 in Run-Test/Idle.
- R7: If the primary IR shift stage holds 4'h3 while the primary TAP is in Update-IR, the rising edge that leaves Update-IR sets sec_active. sec_active is still 0 before that edge.
- R8: sec_active is set on the second consecutive rising TCK edge that samples dbg_evt_n low with trst_n high. A single low sample followed by a high sample does not set it. Edges that occur while trst_n is low are not counted.
- R9: While sec_active is 1, TMS and TDI drive the secondary TAP and TDO comes from it. Its Capture-IR pattern is 4'b0101 (bits leave as 1,0,1,0), and its data register is a one-bit bypass that captures 0.
- R10: Once set, sec_active stays 1 whatever TMS and TDI do. The primary state machine stays in Test-Logic-Reset. Only trst_n low clears sec_active.
- R11: While the primary TAP owns the pins, the secondary state machine is held in Test-Logic-Reset and never drives TDO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low; clears both TAPs and the ownership latch |
| tms | input | 1 | Test mode select, steered to the owning TAP |
| tdi | input | 1 | Test data in, steered to the owning TAP |
| dbg_evt_n | input | 1 | Debug-event request, active low; two consecutive low samples hand the port over |
| tdo | output | 1 | Test data out from the owning TAP, updated on the falling TCK edge |
| tdo_oe | output | 1 | Output enable for tdo, high only while the owning TAP shifts |
| sec_active | output | 1 | Ownership latch: 1 when the secondary debug TAP owns the pins |

## Verification
The hardest cases are where the debug-event counter meets other events. One is a low pulse on the debug-event pin that is one edge short. Another is a low level that is already present while TRST is held and then carries over past reset release. The bench places dbg_evt_n changes between rising edges, with TMS held high so that the primary TAP sits idle in Test-Logic-Reset. It then checks sec_active after each individual edge. This confirms that only the second consecutive low sample taken after reset release takes the port. The instruction path is reached by a full IR scan ending in Update-IR. sec_active is checked once just before the leaving edge and once just after it. The secondary TAP's different capture pattern then shows which controller answers.

// File: rtl/dth_pkg.sv
package dth_pkg;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  // Next state of the standard TAP graph
  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      TLR:     return tms ? TLR    : RTI;
      RTI:     return tms ? SEL_DR : RTI;
      SEL_DR:  return tms ? SEL_IR : CAP_DR;
      CAP_DR:  return tms ? EX1_DR : SH_DR;
      SH_DR:   return tms ? EX1_DR : SH_DR;
      EX1_DR:  return tms ? UPD_DR : PAU_DR;
      PAU_DR:  return tms ? EX2_DR : PAU_DR;
      EX2_DR:  return tms ? UPD_DR : SH_DR;
      UPD_DR:  return tms ? SEL_DR : RTI;
      SEL_IR:  return tms ? TLR    : CAP_IR;
      CAP_IR:  return tms ? EX1_IR : SH_IR;
      SH_IR:   return tms ? EX1_IR : SH_IR;
      EX1_IR:  return tms ? UPD_IR : PAU_IR;
      PAU_IR:  return tms ? EX2_IR : PAU_IR;
      EX2_IR:  return tms ? UPD_IR : SH_IR;
      UPD_IR:  return tms ? SEL_DR : RTI;
      default: return TLR;
    endcase
  endfunction

endpackage

// File: rtl/dth_tap_fsm.sv
module dth_tap_fsm
  import dth_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       hold,
  input  logic       tms,
  output tap_state_e state
);

  // hold pins the controller in Test-Logic-Reset (locked out or hidden)
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)   state <= TLR;
    else if (hold) state <= TLR;
    else           state <= tap_next(state, tms);
  end

endmodule

// File: rtl/dth_pri_regs.sv
module dth_pri_regs
  import dth_pkg::*;
#(
  parameter int              IR_W        = 4,
  parameter int              ID_W        = 32,
  parameter logic [ID_W-1:0] IDCODE      = 32'h1A5C_E0B3,
  parameter logic [IR_W-1:0] OP_IDCODE   = 4'h2,
  parameter logic [IR_W-1:0] OP_HANDOVER = 4'h3,
  parameter logic [IR_W-1:0] IR_CAPTURE  = 4'b0001
)(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       serial_out,
  output logic       handover_req
);

  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_q;
  logic [ID_W-1:0] id_sh;
  logic            byp;
  logic            sel_id;

  assign sel_id = (ir_q == OP_IDCODE);

  // Instruction register: shift stage and decoded hold stage
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        TLR:     ir_q  <= OP_IDCODE;
        CAP_IR:  ir_sh <= IR_CAPTURE;
        SH_IR:   ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        UPD_IR:  ir_q  <= ir_sh;
        default: ;
      endcase
    end
  end

  // Data registers: identification and bypass
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sh <= '0;
      byp   <= 1'b0;
    end else if (state == CAP_DR) begin
      id_sh <= sel_id ? IDCODE : '0;
      byp   <= 1'b0;
    end else if (state == SH_DR) begin
      if (sel_id) id_sh <= {tdi, id_sh[ID_W-1:1]};
      else        byp   <= tdi;
    end
  end

  always_comb begin
    if (state == SH_IR)  serial_out = ir_sh[0];
    else if (sel_id)     serial_out = id_sh[0];
    else                 serial_out = byp;
  end

  assign handover_req = (state == UPD_IR) && (ir_sh == OP_HANDOVER);

endmodule

// File: rtl/dth_sec_tap.sv
module dth_sec_tap
  import dth_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter logic [IR_W-1:0] IR_CAPTURE = 4'b0101
)(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       hidden,
  input  logic       tms,
  input  logic       tdi,
  output tap_state_e state,
  output logic       serial_out
);

  logic [IR_W-1:0] ir_sh;
  logic            byp;

  dth_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .hold   (hidden),
    .tms    (tms),
    .state  (state)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      byp   <= 1'b0;
    end else begin
      case (state)
        CAP_IR:  ir_sh <= IR_CAPTURE;
        SH_IR:   ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        CAP_DR:  byp   <= 1'b0;
        SH_DR:   byp   <= tdi;
        default: ;
      endcase
    end
  end

  assign serial_out = (state == SH_IR) ? ir_sh[0] : byp;

endmodule

// File: rtl/dth_handover_latch.sv
module dth_handover_latch #(
  parameter int DE_CYCLES = 2
)(
  input  logic tck,
  input  logic trst_n,
  input  logic ir_req,
  input  logic de_n,
  output logic owned
);

  localparam int               CNT_W = $clog2(DE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DE_CYCLES - 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(DE_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      cnt   <= '0;
      owned <= 1'b0;
    end else begin
      if (de_n)              cnt <= '0;
      else if (cnt != FULL)  cnt <= cnt + 1'b1;
      // sticky: nothing but trst_n clears it
      if (ir_req || (!de_n && cnt == LAST)) owned <= 1'b1;
    end
  end

endmodule

// File: rtl/dual_tap_handover.sv
module dual_tap_handover
  import dth_pkg::*;
#(
  parameter int              IR_W           = 4,
  parameter int              ID_W           = 32,
  parameter logic [ID_W-1:0] IDCODE         = 32'h1A5C_E0B3,
  parameter logic [IR_W-1:0] OP_IDCODE      = 4'h2,
  parameter logic [IR_W-1:0] OP_HANDOVER    = 4'h3,
  parameter logic [IR_W-1:0] PRI_IR_CAPTURE = 4'b0001,
  parameter logic [IR_W-1:0] SEC_IR_CAPTURE = 4'b0101,
  parameter int              DE_CYCLES      = 2
)(
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic dbg_evt_n,
  output logic tdo,
  output logic tdo_oe,
  output logic sec_active
);

  tap_state_e pri_state;
  tap_state_e sec_state;
  logic       pri_bit;
  logic       sec_bit;
  logic       ho_req;
  logic       owned;
  logic       shifting;

  dth_tap_fsm u_pri_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .hold   (owned),
    .tms    (tms),
    .state  (pri_state)
  );

  dth_pri_regs #(
    .IR_W        (IR_W),
    .ID_W        (ID_W),
    .IDCODE      (IDCODE),
    .OP_IDCODE   (OP_IDCODE),
    .OP_HANDOVER (OP_HANDOVER),
    .IR_CAPTURE  (PRI_IR_CAPTURE)
  ) u_pri (
    .tck          (tck),
    .trst_n       (trst_n),
    .state        (pri_state),
    .tdi          (tdi),
    .serial_out   (pri_bit),
    .handover_req (ho_req)
  );

  dth_sec_tap #(
    .IR_W       (IR_W),
    .IR_CAPTURE (SEC_IR_CAPTURE)
  ) u_sec (
    .tck        (tck),
    .trst_n     (trst_n),
    .hidden     (!owned),
    .tms        (tms),
    .tdi        (tdi),
    .state      (sec_state),
    .serial_out (sec_bit)
  );

  dth_handover_latch #(
    .DE_CYCLES (DE_CYCLES)
  ) u_latch (
    .tck    (tck),
    .trst_n (trst_n),
    .ir_req (ho_req),
    .de_n   (dbg_evt_n),
    .owned  (owned)
  );

  always_comb begin
    if (owned) shifting = (sec_state == SH_DR) || (sec_state == SH_IR);
    else       shifting = (pri_state == SH_DR) || (pri_state == SH_IR);
  end

  // Single falling-edge output stage after the ownership mux
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= shifting ? (owned ? sec_bit : pri_bit) : 1'b0;
      tdo_oe <= shifting;
    end
  end

  assign sec_active = owned;

endmodule

// File: rtl/dual_tap_handover_chk.sv
module dual_tap_handover_chk
  import dth_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input logic       dbg_evt_n,
  input logic       owned,
  input logic       ho_req,
  input tap_state_e pri_state,
  input tap_state_e sec_state,
  input logic       tdo_oe
);

  p_idle_oe_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (!owned && pri_state == RTI) |-> !tdo_oe);

  p_ir_handover_r7: assert property (@(posedge tck) disable iff (!trst_n)
    ho_req |=> owned);

  // written for the default two-sample debug-event window
  p_de_handover_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (!dbg_evt_n && $past(!dbg_evt_n) && $past(trst_n)) |=> owned);

  p_sticky_r10: assert property (@(posedge tck) disable iff (!trst_n)
    owned |=> owned);

  p_pri_locked_r10: assert property (@(posedge tck) disable iff (!trst_n)
    owned |=> (pri_state == TLR));

  p_sec_hidden_r11: assert property (@(posedge tck) disable iff (!trst_n)
    !owned |-> (sec_state == TLR));

endmodule

bind dual_tap_handover dual_tap_handover_chk u_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .dbg_evt_n (dbg_evt_n),
  .owned     (owned),
  .ho_req    (ho_req),
  .pri_state (pri_state),
  .sec_state (sec_state),
  .tdo_oe    (tdo_oe)
);

// File: tb/dual_tap_handover_tb.sv
module dual_tap_handover_tb;

  localparam logic [31:0] ID = 32'h1A5C_E0B3;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, dbg_evt_n = 1'b1;
  logic tdo, tdo_oe, sec_active;

  always #10 tck = ~tck;  // 50 MHz

  dual_tap_handover u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .dbg_evt_n(dbg_evt_n),
    .tdo(tdo), .tdo_oe(tdo_oe), .sec_active(sec_active)
  );

  typedef struct { int mode; logic tdo; logic oe; string req; } exp_t;
  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one TCK cycle. Expectation refers to the state current in this cycle,
  // tms/tdi steer the next rising edge. mode 1: check oe, mode 2: oe and tdo.
  task automatic step(input logic t, input logic d, input int mode = 0,
                      input logic et = 1'b0, input logic eo = 1'b0, input string req = "");
    exp_t e;
    @(posedge tck); #2;
    tms = t; tdi = d;
    if (mode != 0) begin
      e.mode = mode; e.tdo = et; e.oe = eo; e.req = req;
      q.push_back(e);
    end
  endtask

  // Monitor: compare after each falling edge
  initial forever begin
    exp_t e;
    @(negedge tck); #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      check({e.req, " oe"}, tdo_oe, e.oe);
      if (e.mode == 2) check({e.req, " tdo"}, tdo, e.tdo);
    end
  end

  task automatic to_tlr();
    repeat (5) step(1'b1, 1'b0);
  endtask

  // From Run-Test/Idle; returns in Update-IR with TMS low
  task automatic scan_ir(input logic [3:0] din, input logic [3:0] exp, input string req);
    step(1'b1, 1'b0, 1, 1'b0, 1'b0, {req, " R6 idle"});
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(i == 3, din[i], 2, exp[i], 1'b1, req);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // From Run-Test/Idle; returns in Update-DR with TMS low
  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] exp, input string req);
    step(1'b1, 1'b0, 1, 1'b0, 1'b0, {req, " R6 idle"});
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i], 2, exp[i], 1'b1, req);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  initial begin
    #25;
    check("R1 reset sec_active", sec_active, 0);
    check("R1 reset tdo_oe", tdo_oe, 0);
    check("R1 reset tdo", tdo, 0);
    @(posedge tck); #2 trst_n = 1'b1;
    step(1'b0, 1'b0);                                   // TLR -> RTI
    scan_dr(32, 64'h0, {32'h0, ID}, "R1 R4 idcode");
    scan_ir(4'hF, 4'b0001, "R3 R11 capture");           // primary answers, secondary hidden
    scan_dr(8, 64'hB2, 64'hB2 << 1, "R5 bypass");
    scan_ir(4'h5, 4'b0001, "R3 unused opcode");
    scan_dr(6, 64'h35, 64'h35 << 1, "R3 unused opcode bypass");
    scan_ir(4'h2, 4'b0001, "R3 idcode opcode");
    scan_dr(32, 64'hFFFF_FFFF, {32'h0, ID}, "R3 R4 idcode opcode");
    scan_ir(4'hF, 4'b0001, "R3 bypass opcode");
    to_tlr();
    step(1'b0, 1'b0);
    scan_dr(32, 64'h0, {32'h0, ID}, "R2 tlr selects idcode");

    // Handover by instruction
    scan_ir(4'h3, 4'b0001, "R7 load");
    check("R7 not before update edge", sec_active, 0);
    step(1'b0, 1'b0);
    check("R7 handover on update", sec_active, 1);
    scan_ir(4'h0, 4'b0101, "R9 secondary capture");
    scan_dr(5, 64'h19, 64'h19 << 1, "R9 secondary bypass");
    repeat (8) step(1'b1, 1'b1);
    check("R10 sticky after tms", sec_active, 1);
    step(1'b0, 1'b0);
    scan_ir(4'h2, 4'b0101, "R10 primary locked");

    // TRST clears ownership
    @(posedge tck); #2 trst_n = 1'b0; tms = 1'b1;
    #5;
    check("R10 trst clears", sec_active, 0);
    check("R1 trst oe", tdo_oe, 0);
    #15 trst_n = 1'b1;
    step(1'b0, 1'b0);
    scan_dr(32, 64'h0, {32'h0, ID}, "R1 primary back");
    to_tlr();

    // Debug event: single low sample
    @(posedge tck); #2 dbg_evt_n = 1'b0;
    @(posedge tck); #2 dbg_evt_n = 1'b1;
    repeat (3) @(posedge tck);
    #2 check("R8 single low ignored", sec_active, 0);
    // Two consecutive low samples
    @(posedge tck); #2 dbg_evt_n = 1'b0;
    @(posedge tck); #2 check("R8 one low sample", sec_active, 0);
    @(posedge tck); #2 check("R8 two low samples", sec_active, 1);
    dbg_evt_n = 1'b1;
    step(1'b0, 1'b0);
    scan_ir(4'h1, 4'b0101, "R8 R9 secondary after event");

    // Low level held through reset: only edges after release count
    @(posedge tck); #2 trst_n = 1'b0; tms = 1'b1; dbg_evt_n = 1'b0;
    repeat (3) @(posedge tck);
    #2 trst_n = 1'b1;
    check("R8 not during reset", sec_active, 0);
    @(posedge tck); #2 check("R8 first edge after release", sec_active, 0);
    @(posedge tck); #2 check("R8 second edge after release", sec_active, 1);
    dbg_evt_n = 1'b1;

    repeat (4) @(posedge tck);
    if (q.size() != 0) check("scoreboard drained", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule